// File: doc/BRIEF.md
# Input Channel Selector with Rotation and Peak Alternation

This block decides which pair of analog inputs feeds a dual-slope converter for each conversion. It drives one-hot select lines for the high-side and low-side analog switches. The selection comes from one of three sources. A static 2-bit channel code can pick it. An automatic rotation can step through the channels. A peak mode can route a dedicated peak-hold input against analog ground, with conversions that alternate between a maximum and a minimum reading.

The selection changes only on the end-of-cycle strobe from the conversion sequencer. A result is always paired with the routing that was active while it was integrated. On each strobe the block latches a tag for the result that just finished. The tag carries the channel number plus a maximum flag and a minimum flag. The peak and peak-calibration modes are refused while the buzzer is on.

Top module: `chan_sel_ctrl`

## Requirements
- R1: After reset the active channel is code 00, so `hi_sel_o`=4'b0001 and `lo_sel_o`=3'b001. Peak mode is off, and `res_chan_o`, `res_max_o` and `res_min_o` are all zero.
- R2: In normal routing, the high select is bit 0 for the main input, bit 1 for the first auxiliary input and bit 2 for the second auxiliary input. Codes 00, 01 and 10 select these three inputs in that order, each with `lo_sel_o` bit 0, the common low.
- R3: Code 11 selects `hi_sel_o` bit 2 (second auxiliary) with `lo_sel_o` bit 1 (first auxiliary).
- R4: Routing and result tags change only on a rising clock edge with `eoc_i` high. Input changes at any other time have no effect on the outputs.
- R5: With rotation on and a code other than 11, each strobe advances the channel 00→01→10→00. Any channel other than 00 or 01 steps to 00.
- R6: With rotation on and code 11, each strobe moves channel 00 to 11, and any other channel to 00.
- R7: In peak mode the routing is `hi_sel_o` bit 3 (peak input) with `lo_sel_o` bit 2 (analog ground). The first peak conversion is a maximum, and later strobes alternate minimum and maximum.
- R8: On each strobe, `res_chan_o` takes the channel of the cycle that just ended. `res_max_o` and `res_min_o` mark a peak maximum or peak minimum result. The two flags are never both high.
- R9: While `buzz_en_i` is high, the peak and peak-calibration enables are ignored and the next cycle uses normal routing.
- R10: On the strobe that leaves peak mode, or whenever rotation is off, the next channel is the programmed code.
- R11: The peak-calibration enable routes and alternates exactly like the peak enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_code_i | input | 2 | Programmed channel code |
| rot_en_i | input | 1 | Rotation enable |
| peak_en_i | input | 1 | Peak mode enable |
| pcal_en_i | input | 1 | Peak calibration enable |
| buzz_en_i | input | 1 | Buzzer on; blocks peak modes |
| eoc_i | input | 1 | End-of-conversion strobe, one cycle |
| hi_sel_o | output | 4 | One-hot high-side switch select |
| lo_sel_o | output | 3 | One-hot low-side switch select |
| res_chan_o | output | 2 | Channel of the latest result |
| res_max_o | output | 1 | Latest result is a peak maximum |
| res_min_o | output | 1 | Latest result is a peak minimum |

## Verification
The assertions assume that `eoc_i` is a single-cycle strobe and that the mode inputs are steady at the edge where the strobe is sampled. The bench changes mode and code inputs only on falling edges. It raises `eoc_i` for exactly one clock period per conversion. Before each strobe it changes the inputs and checks that the routing has not moved. The bench covers both rotation patterns, a code change in the middle of a rotation, peak entry and exit, the buzzer block, and calibration.

// File: rtl/chan_sel_pkg.sv
package chan_sel_pkg;
  localparam int CODE_W = 2;
  localparam int HI_W   = 4;
  localparam int LO_W   = 3;
  localparam int HI_IW  = $clog2(HI_W);
  localparam int LO_IW  = $clog2(LO_W);

  typedef enum logic [CODE_W-1:0] {
    CH1 = 2'b00,
    CH2 = 2'b01,
    CH3 = 2'b10,
    CH4 = 2'b11
  } chan_e;

  localparam int HI_MAIN = 0;
  localparam int HI_AUX1 = 1;
  localparam int HI_AUX2 = 2;
  localparam int HI_PEAK = 3;
  localparam int LO_COM  = 0;
  localparam int LO_AUX1 = 1;
  localparam int LO_GND  = 2;
endpackage

// File: rtl/chan_step.sv
module chan_step
  import chan_sel_pkg::*;
(
  input  logic [CODE_W-1:0] cur_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rot_i,
  output logic [CODE_W-1:0] nxt_o
);
  always_comb begin
    if (!rot_i) begin
      nxt_o = code_i;
    end else if (code_i == CH4) begin
      nxt_o = (cur_i == CH1) ? CH4 : CH1;   // two-pair rotation
    end else begin
      unique case (cur_i)
        CH1:     nxt_o = CH2;
        CH2:     nxt_o = CH3;
        default: nxt_o = CH1;
      endcase
    end
  end
endmodule

// File: rtl/peak_phase_reg.sv
module peak_phase_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eoc_i,
  input  logic peak_ok_i,
  output logic peak_act_o,
  output logic phase_min_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_act_o  <= 1'b0;
      phase_min_o <= 1'b0;
    end else if (eoc_i) begin
      peak_act_o  <= peak_ok_i;
      // first peak conversion is a maximum
      phase_min_o <= peak_ok_i && peak_act_o && !phase_min_o;
    end
  end

  a_r7_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && peak_ok_i && peak_act_o |=> phase_min_o != $past(phase_min_o));
  a_r7_first_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && peak_ok_i && !peak_act_o |=> peak_act_o && !phase_min_o);
endmodule

// File: rtl/sel_decode.sv
module sel_decode
  import chan_sel_pkg::*;
(
  input  logic [CODE_W-1:0] cur_i,
  input  logic              peak_i,
  output logic [HI_W-1:0]   hi_o,
  output logic [LO_W-1:0]   lo_o
);
  logic [HI_IW-1:0] hi_idx;
  logic [LO_IW-1:0] lo_idx;

  always_comb begin
    if (peak_i) begin
      hi_idx = HI_IW'(HI_PEAK);
      lo_idx = LO_IW'(LO_GND);
    end else if (cur_i == CH4) begin
      hi_idx = HI_IW'(HI_AUX2);
      lo_idx = LO_IW'(LO_AUX1);
    end else begin
      hi_idx = HI_IW'(cur_i);
      lo_idx = LO_IW'(LO_COM);
    end
  end

  for (genvar i = 0; i < HI_W; i++) begin : g_hi
    assign hi_o[i] = (hi_idx == HI_IW'(i));
  end
  for (genvar j = 0; j < LO_W; j++) begin : g_lo
    assign lo_o[j] = (lo_idx == LO_IW'(j));
  end
endmodule

// File: rtl/chan_sel_ctrl.sv
module chan_sel_ctrl
  import chan_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] chan_code_i,
  input  logic              rot_en_i,
  input  logic              peak_en_i,
  input  logic              pcal_en_i,
  input  logic              buzz_en_i,
  input  logic              eoc_i,
  output logic [HI_W-1:0]   hi_sel_o,
  output logic [LO_W-1:0]   lo_sel_o,
  output logic [CODE_W-1:0] res_chan_o,
  output logic              res_max_o,
  output logic              res_min_o
);
  logic [CODE_W-1:0] cur_q, nxt_ch;
  logic peak_ok, peak_act, phase_min;

  assign peak_ok = (peak_en_i || pcal_en_i) && !buzz_en_i;

  // no rotation step on the strobe that leaves peak mode
  chan_step u_step (
    .cur_i  (cur_q),
    .code_i (chan_code_i),
    .rot_i  (rot_en_i && !peak_ok && !peak_act),
    .nxt_o  (nxt_ch)
  );

  peak_phase_reg u_peak (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eoc_i       (eoc_i),
    .peak_ok_i   (peak_ok),
    .peak_act_o  (peak_act),
    .phase_min_o (phase_min)
  );

  sel_decode u_dec (
    .cur_i  (cur_q),
    .peak_i (peak_act),
    .hi_o   (hi_sel_o),
    .lo_o   (lo_sel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= CH1;
      res_chan_o <= CH1;
      res_max_o  <= 1'b0;
      res_min_o  <= 1'b0;
    end else if (eoc_i) begin
      cur_q      <= nxt_ch;
      res_chan_o <= cur_q;
      res_max_o  <= peak_act && !phase_min;
      res_min_o  <= peak_act && phase_min;
    end
  end

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_i |=> $stable(hi_sel_o) && $stable(lo_sel_o) && $stable(res_chan_o)
               && $stable(res_max_o) && $stable(res_min_o));
  a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_max_o && res_min_o));
  a_r8_peak_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && hi_sel_o[HI_PEAK] |=> res_max_o || res_min_o);
  a_r9_buzz_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && buzz_en_i |=> !hi_sel_o[HI_PEAK] && !lo_sel_o[LO_GND]);
  a_r3_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && !peak_ok && !rot_en_i && chan_code_i == CH4
      |=> hi_sel_o[HI_AUX2] && lo_sel_o[LO_AUX1]);
  a_r6_pair_rot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && !peak_ok && !peak_act && rot_en_i && chan_code_i == CH4 && cur_q == CH1
      |=> hi_sel_o[HI_AUX2] && lo_sel_o[LO_AUX1]);
  a_r10_exit_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && peak_act && !peak_ok |=> cur_q == $past(chan_code_i));
endmodule

// File: tb/tb_chan_sel_ctrl.sv
module tb_chan_sel_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] code = 2'b00;
  logic       rot = 1'b0, pk = 1'b0, pc = 1'b0, bz = 1'b0, eoc = 1'b0;
  logic [3:0] hi;
  logic [2:0] lo;
  logic [1:0] rchan;
  logic       rmax, rmin;

  int n_chk = 0;
  int n_err = 0;

  logic [1:0] m_ch = 2'b00;
  logic       m_pk = 1'b0, m_ph = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  chan_sel_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_code_i(code), .rot_en_i(rot),
    .peak_en_i(pk), .pcal_en_i(pc), .buzz_en_i(bz), .eoc_i(eoc),
    .hi_sel_o(hi), .lo_sel_o(lo), .res_chan_o(rchan),
    .res_max_o(rmax), .res_min_o(rmin)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] route(input logic [1:0] ch, input logic p);
    if (p)              return {4'b1000, 3'b100};
    else if (ch == 2'd3) return {4'b0100, 3'b010};
    else if (ch == 2'd2) return {4'b0100, 3'b001};
    else if (ch == 2'd1) return {4'b0010, 3'b001};
    else                 return {4'b0001, 3'b001};
  endfunction

  // driver: set inputs, check routing held, push expected tag, strobe
  task automatic conv(input logic [1:0] c, input logic r, input logic p,
                      input logic q, input logic b, input string tag);
    logic ok;
    @(negedge clk);
    code = c; rot = r; pk = p; pc = q; bz = b;
    check({tag, "/R4 sel"}, {1'b0, hi, lo}, {1'b0, route(m_ch, m_pk)});
    exp_q.push_back({m_ch, m_pk && !m_ph, m_pk && m_ph});
    tag_q.push_back(tag);
    eoc = 1'b1;
    ok = (p || q) && !b;
    if (ok) begin
      m_ph = m_pk ? !m_ph : 1'b0;
      m_pk = 1'b1;
      m_ch = c;
    end else begin
      if (r && !m_pk) begin
        if (c == 2'd3) m_ch = (m_ch == 2'd0) ? 2'd3 : 2'd0;
        else m_ch = (m_ch == 2'd0) ? 2'd1 : (m_ch == 2'd1) ? 2'd2 : 2'd0;
      end else m_ch = c;
      m_pk = 1'b0;
      m_ph = 1'b0;
    end
    @(negedge clk);
    eoc = 1'b0;
  endtask

  // monitor: compare result tag after each strobe
  initial begin
    forever begin
      @(posedge clk);
      if (eoc === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("R8 unexpected result", 8'h1, 8'h0);
        end else begin
          logic [3:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, "/R8 tag"}, {4'b0, rchan, rmax, rmin}, {4'b0, e});
        end
      end
    end
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset sel", {1'b0, hi, lo}, {1'b0, 4'b0001, 3'b001});
    check("R1 reset tag", {4'b0, rchan, rmax, rmin}, 8'h0);
    rst_n = 1'b1;
    // R2/R3 static codes
    conv(2'd1, 0, 0, 0, 0, "R2");
    conv(2'd2, 0, 0, 0, 0, "R2");
    conv(2'd3, 0, 0, 0, 0, "R3");
    conv(2'd0, 0, 0, 0, 0, "R3");
    conv(2'd0, 0, 0, 0, 0, "R2");
    // R5 three-channel rotation, code change to 10 mid-run
    for (int i = 0; i < 4; i++) conv(2'd0, 1, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) conv(2'd2, 1, 0, 0, 0, "R5");
    // R6 pair rotation entered from channel 01
    for (int i = 0; i < 5; i++) conv(2'd3, 1, 0, 0, 0, "R6");
    // R10 rotation off
    conv(2'd1, 0, 0, 0, 0, "R10");
    conv(2'd1, 0, 0, 0, 0, "R10");
    // R7 peak alternation
    for (int i = 0; i < 5; i++) conv(2'd2, 0, 1, 0, 0, "R7");
    // R10 leave peak with rotation on: code first, then steps
    for (int i = 0; i < 3; i++) conv(2'd0, 1, 0, 0, 0, "R10");
    // R9 buzzer blocks peak and calibration
    conv(2'd1, 0, 1, 0, 1, "R9");
    conv(2'd1, 0, 1, 1, 1, "R9");
    conv(2'd3, 0, 0, 1, 1, "R9");
    // R11 calibration behaves as peak, re-entry starts with max
    for (int i = 0; i < 4; i++) conv(2'd1, 0, 0, 1, 0, "R11");
    conv(2'd3, 0, 0, 0, 1, "R10");
    for (int i = 0; i < 3; i++) conv(2'd0, 0, 1, 0, 0, "R7");
    conv(2'd0, 0, 0, 0, 0, "R10");
    // R4 inputs wiggle without strobe
    @(negedge clk);
    code = 2'd3; rot = 1'b1; pk = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 no strobe", {1'b0, hi, lo}, {1'b0, route(m_ch, m_pk)});
    repeat (3) @(negedge clk);
    check("R8 queue drained", 8'(exp_q.size()), 8'h0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule